// File: doc/BRIEF.md
# Deduplication Hash Bucket Manager

This block keeps a table of hash buckets for a deduplicated cache. Each bucket has a fixed number of nodes, and each node points at one location in the data array. A detection stage hands the block an insert request: a bucket index and the data-array pointer of a block that was just analysed. The block stores the pointer in a free node of that bucket. If the bucket is full, the block resolves the collision.

To resolve a collision, the block picks a node whose data is held by exactly one tag. It invalidates that block from the data array, then from the tag array. It then overwrites the node with the new pointer. If every node in the full bucket points at shared data, the request is dropped. No node changes, and no invalidation is sent, so the one-to-one tag-to-data mapping of the incoming block is kept. A separate update port sets or clears the shared flag of any node as reference counts change.

Only one request is handled at a time. Every accepted request ends with a single-cycle response. The response reports how the request ended and, for a replacement, which pointer was evicted.

Top module: `dedup_bucket_mgr`

## Requirements
- R1: After reset, `ins_ready` is 1, `rsp_valid` is 0, both invalidation requests are 0, and every node of every bucket is empty.
- R2: If the target bucket has at least one empty node, the lowest-indexed empty node takes the new pointer with its shared flag cleared. The response has status 0 (stored-in-free) and reports that node index.
- R3: No invalidation request is raised for a request whose bucket still has an empty node.
- R4: If the bucket is full, the victim is the lowest-indexed node whose shared flag is 0. The response has status 1 (replaced), reports the victim index, and gives the victim's old pointer on `rsp_evict_ptr`.
- R5: A replacement first raises `dinv_req` with `inv_ptr` equal to the victim's pointer. It holds the request until `dinv_rdy`, then waits for a one-cycle `dinv_ack`. Only after that ack does it raise `tinv_req` with the same pointer, under the same handshake rules using `tinv_rdy` and `tinv_ack`. Each handshake occurs exactly once.
- R6: After the tag ack, the victim node holds the new pointer with its shared flag cleared.
- R7: If the bucket is full and every node is shared, the response has status 2 (skipped). No invalidation request is raised, and the bucket is left as it was.
- R8: `ins_ready` is 1 only while no request is in progress. It falls in the cycle after a request is accepted and stays 0 until the response has been given.
- R9: A pulse on `shr_valid` sets the shared flag of the node addressed by `shr_bucket`/`shr_node` to `shr_flag`. The flag affects only later victim choices.
- R10: `rsp_valid` is a single-cycle pulse, one for each accepted request. `rsp_evict_ptr` is 0 unless the status is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ins_valid | input | 1 | Insert request valid |
| ins_ready | output | 1 | Block idle; can accept an insert |
| ins_bucket | input | BKT_W | Target bucket index |
| ins_ptr | input | PTR_W | Data-array pointer to store |
| rsp_valid | output | 1 | One-cycle response pulse |
| rsp_status | output | 2 | 0 stored-in-free, 1 replaced, 2 skipped |
| rsp_node | output | NODE_W | Node written (0 when skipped) |
| rsp_evict_ptr | output | PTR_W | Pointer evicted by a replacement, else 0 |
| inv_ptr | output | PTR_W | Pointer being invalidated |
| dinv_req | output | 1 | Data-array invalidation request |
| dinv_rdy | input | 1 | Data array accepts the request |
| dinv_ack | input | 1 | Data-array invalidation complete |
| tinv_req | output | 1 | Tag-array invalidation request |
| tinv_rdy | input | 1 | Tag array accepts the request |
| tinv_ack | input | 1 | Tag-array invalidation complete |
| shr_valid | input | 1 | Shared-flag update strobe |
| shr_bucket | input | BKT_W | Bucket of the flag update |
| shr_node | input | NODE_W | Node of the flag update |
| shr_flag | input | 1 | New shared flag value |

## Verification
The bench builds the block with 4 buckets of 4 nodes and 8-bit pointers. With so few nodes, a short run of random inserts fills buckets, so full buckets, victim choice and the skip path occur many times, not just rarely. Random shared-flag updates mixed with the inserts produce every mix of shared and unshared nodes in a full bucket, including the all-shared case. Random ready and ack delays on both arrays exercise held requests and the ordering of data before tag.

// File: rtl/dedup_pkg.sv
package dedup_pkg;

  typedef enum logic [2:0] {
    ST_IDLE     = 3'd0,
    ST_SCAN     = 3'd1,
    ST_INV_DATA = 3'd2,
    ST_INV_TAG  = 3'd3,
    ST_WRITE    = 3'd4,
    ST_DONE     = 3'd5
  } mgr_state_e;

  typedef enum logic [1:0] {
    OUT_FREE = 2'd0,
    OUT_REPL = 2'd1,
    OUT_SKIP = 2'd2
  } outcome_e;

endpackage

// File: rtl/dedup_bucket_store.sv
module dedup_bucket_store #(
  parameter int NUM_BUCKETS = 64,
  parameter int NODES       = 16,
  parameter int PTR_W       = 12,
  localparam int BKT_W      = $clog2(NUM_BUCKETS),
  localparam int NODE_W     = $clog2(NODES)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [BKT_W-1:0]            rd_bucket,
  output logic [NODES-1:0]            rd_valid,
  output logic [NODES-1:0]            rd_shared,
  output logic [NODES-1:0][PTR_W-1:0] rd_ptr,
  input  logic                        wr_en,
  input  logic [BKT_W-1:0]            wr_bucket,
  input  logic [NODE_W-1:0]           wr_node,
  input  logic [PTR_W-1:0]            wr_ptr,
  input  logic                        su_en,
  input  logic [BKT_W-1:0]            su_bucket,
  input  logic [NODE_W-1:0]           su_node,
  input  logic                        su_flag
);

  logic [NODES-1:0]            valid_q  [NUM_BUCKETS];
  logic [NODES-1:0]            shared_q [NUM_BUCKETS];
  logic [NODES-1:0][PTR_W-1:0] ptr_q    [NUM_BUCKETS];

  // a node write and a flag update to the same node: the write wins
  logic su_hits_write;
  assign su_hits_write = wr_en && (wr_bucket == su_bucket) && (wr_node == su_node);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int b = 0; b < NUM_BUCKETS; b++) begin
        valid_q[b]  <= '0;
        shared_q[b] <= '0;
        ptr_q[b]    <= '0;
      end
    end else begin
      if (su_en && !su_hits_write)
        shared_q[su_bucket][su_node] <= su_flag;
      if (wr_en) begin
        valid_q[wr_bucket][wr_node]  <= 1'b1;
        shared_q[wr_bucket][wr_node] <= 1'b0;
        ptr_q[wr_bucket][wr_node]    <= wr_ptr;
      end
    end
  end

  assign rd_valid  = valid_q[rd_bucket];
  assign rd_shared = shared_q[rd_bucket];
  assign rd_ptr    = ptr_q[rd_bucket];

endmodule

// File: rtl/dedup_node_picker.sv
module dedup_node_picker #(
  parameter int NODES   = 16,
  localparam int NODE_W = $clog2(NODES)
) (
  input  logic [NODES-1:0]  node_valid,
  input  logic [NODES-1:0]  node_shared,
  output logic              free_found,
  output logic [NODE_W-1:0] free_idx,
  output logic              vic_found,
  output logic [NODE_W-1:0] vic_idx
);

  function automatic logic [NODE_W-1:0] lowest_set(input logic [NODES-1:0] v);
    logic [NODE_W-1:0] r;
    r = '0;
    for (int i = NODES - 1; i >= 0; i--)
      if (v[i]) r = NODE_W'(i);
    return r;
  endfunction

  logic [NODES-1:0] empty_vec;
  logic [NODES-1:0] unshared_vec;

  assign empty_vec    = ~node_valid;
  assign unshared_vec = node_valid & ~node_shared;

  assign free_found = |empty_vec;
  assign free_idx   = lowest_set(empty_vec);
  assign vic_found  = |unshared_vec;
  assign vic_idx    = lowest_set(unshared_vec);

  always_comb begin
    if (free_found)
      AST_FREE_IS_EMPTY: assert (!node_valid[free_idx]); // R2
    if (vic_found)
      AST_VICTIM_UNSHARED: assert (node_valid[vic_idx] && !node_shared[vic_idx]); // R4
  end

endmodule

// File: rtl/dedup_bucket_mgr.sv
module dedup_bucket_mgr
  import dedup_pkg::*;
#(
  parameter int NUM_BUCKETS = 64,
  parameter int NODES       = 16,
  parameter int PTR_W       = 12,
  localparam int BKT_W      = $clog2(NUM_BUCKETS),
  localparam int NODE_W     = $clog2(NODES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ins_valid,
  output logic              ins_ready,
  input  logic [BKT_W-1:0]  ins_bucket,
  input  logic [PTR_W-1:0]  ins_ptr,
  output logic              rsp_valid,
  output logic [1:0]        rsp_status,
  output logic [NODE_W-1:0] rsp_node,
  output logic [PTR_W-1:0]  rsp_evict_ptr,
  output logic [PTR_W-1:0]  inv_ptr,
  output logic              dinv_req,
  input  logic              dinv_rdy,
  input  logic              dinv_ack,
  output logic              tinv_req,
  input  logic              tinv_rdy,
  input  logic              tinv_ack,
  input  logic              shr_valid,
  input  logic [BKT_W-1:0]  shr_bucket,
  input  logic [NODE_W-1:0] shr_node,
  input  logic              shr_flag
);

  mgr_state_e        state_q;
  outcome_e          outcome_q;
  logic [BKT_W-1:0]  bkt_q;
  logic [PTR_W-1:0]  new_ptr_q;
  logic [PTR_W-1:0]  vic_ptr_q;
  logic [NODE_W-1:0] sel_q;
  logic              sent_q;

  logic [NODES-1:0]            rd_valid;
  logic [NODES-1:0]            rd_shared;
  logic [NODES-1:0][PTR_W-1:0] rd_ptr;
  logic                        pk_free_found;
  logic [NODE_W-1:0]           pk_free_idx;
  logic                        pk_vic_found;
  logic [NODE_W-1:0]           pk_vic_idx;
  logic                        wr_en;

  // named internal events used by the assertions
  logic ev_accept;
  logic ev_scan_free;
  logic ev_scan_repl;
  logic ev_scan_skip;

  assign ev_accept    = (state_q == ST_IDLE) && ins_valid;
  assign ev_scan_free = (state_q == ST_SCAN) && pk_free_found;
  assign ev_scan_repl = (state_q == ST_SCAN) && !pk_free_found && pk_vic_found;
  assign ev_scan_skip = (state_q == ST_SCAN) && !pk_free_found && !pk_vic_found;

  dedup_bucket_store #(
    .NUM_BUCKETS (NUM_BUCKETS),
    .NODES       (NODES),
    .PTR_W       (PTR_W)
  ) u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_bucket (bkt_q),
    .rd_valid  (rd_valid),
    .rd_shared (rd_shared),
    .rd_ptr    (rd_ptr),
    .wr_en     (wr_en),
    .wr_bucket (bkt_q),
    .wr_node   (sel_q),
    .wr_ptr    (new_ptr_q),
    .su_en     (shr_valid),
    .su_bucket (shr_bucket),
    .su_node   (shr_node),
    .su_flag   (shr_flag)
  );

  dedup_node_picker #(.NODES(NODES)) u_pick (
    .node_valid  (rd_valid),
    .node_shared (rd_shared),
    .free_found  (pk_free_found),
    .free_idx    (pk_free_idx),
    .vic_found   (pk_vic_found),
    .vic_idx     (pk_vic_idx)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      outcome_q <= OUT_FREE;
      bkt_q     <= '0;
      new_ptr_q <= '0;
      vic_ptr_q <= '0;
      sel_q     <= '0;
      sent_q    <= 1'b0;
    end else begin
      case (state_q)
        ST_IDLE: if (ins_valid) begin
          bkt_q     <= ins_bucket;
          new_ptr_q <= ins_ptr;
          state_q   <= ST_SCAN;
        end
        ST_SCAN: begin
          sent_q <= 1'b0;
          if (ev_scan_free) begin
            sel_q     <= pk_free_idx;
            vic_ptr_q <= '0;
            outcome_q <= OUT_FREE;
            state_q   <= ST_WRITE;
          end else if (ev_scan_repl) begin
            sel_q     <= pk_vic_idx;
            vic_ptr_q <= rd_ptr[pk_vic_idx];
            outcome_q <= OUT_REPL;
            state_q   <= ST_INV_DATA;
          end else begin
            sel_q     <= '0;
            vic_ptr_q <= '0;
            outcome_q <= OUT_SKIP;
            state_q   <= ST_DONE;
          end
        end
        ST_INV_DATA: begin
          if (!sent_q && dinv_rdy) sent_q <= 1'b1;
          else if (sent_q && dinv_ack) begin
            sent_q  <= 1'b0;
            state_q <= ST_INV_TAG;
          end
        end
        ST_INV_TAG: begin
          if (!sent_q && tinv_rdy) sent_q <= 1'b1;
          else if (sent_q && tinv_ack) begin
            sent_q  <= 1'b0;
            state_q <= ST_WRITE;
          end
        end
        ST_WRITE: state_q <= ST_DONE;
        ST_DONE:  state_q <= ST_IDLE;
        default:  state_q <= ST_IDLE;
      endcase
    end
  end

  assign wr_en         = (state_q == ST_WRITE);
  assign ins_ready     = (state_q == ST_IDLE);
  assign rsp_valid     = (state_q == ST_DONE);
  assign rsp_status    = outcome_q;
  assign rsp_node      = sel_q;
  assign rsp_evict_ptr = vic_ptr_q;
  assign inv_ptr       = vic_ptr_q;
  assign dinv_req      = (state_q == ST_INV_DATA) && !sent_q;
  assign tinv_req      = (state_q == ST_INV_TAG) && !sent_q;

  AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    ev_accept |=> !ins_ready); // R8

  AST_TAG_AFTER_DATA_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tinv_req) |-> $past(dinv_ack)); // R5

  AST_DATA_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    dinv_req && !dinv_rdy |=> dinv_req && $stable(inv_ptr)); // R5

  AST_TAG_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    tinv_req && !tinv_rdy |=> tinv_req && $stable(inv_ptr)); // R5

  AST_FREE_NO_INV: assert property (@(posedge clk) disable iff (!rst_n)
    ev_scan_free |=> wr_en && !dinv_req && !tinv_req); // R3

  AST_SKIP_REPORTED: assert property (@(posedge clk) disable iff (!rst_n)
    ev_scan_skip |=> rsp_valid && rsp_status == 2'd2 && !dinv_req); // R7

  AST_RSP_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid); // R10

  AST_EVICT_ONLY_REPL: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_status != 2'd1 |-> rsp_evict_ptr == '0); // R10

  AST_REPL_STARTS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    ev_scan_repl |=> dinv_req && !tinv_req); // R5

endmodule

// File: tb/sim_dedup_bucket_mgr.sv
`timescale 1ns/1ps
module sim_dedup_bucket_mgr;

  localparam int NB = 4;
  localparam int NN = 4;
  localparam int PW = 8;
  localparam int BW = $clog2(NB);
  localparam int NW = $clog2(NN);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ins_valid = 1'b0;
  logic ins_ready;
  logic [BW-1:0] ins_bucket = '0;
  logic [PW-1:0] ins_ptr = '0;
  logic rsp_valid;
  logic [1:0] rsp_status;
  logic [NW-1:0] rsp_node;
  logic [PW-1:0] rsp_evict_ptr;
  logic [PW-1:0] inv_ptr;
  logic dinv_req, tinv_req;
  logic dinv_rdy = 1'b0, dinv_ack = 1'b0, tinv_rdy = 1'b0, tinv_ack = 1'b0;
  logic shr_valid = 1'b0;
  logic [BW-1:0] shr_bucket = '0;
  logic [NW-1:0] shr_node = '0;
  logic shr_flag = 1'b0;

  always #4 clk = ~clk;

  dedup_bucket_mgr #(.NUM_BUCKETS(NB), .NODES(NN), .PTR_W(PW)) u0 (
    .clk(clk), .rst_n(rst_n), .ins_valid(ins_valid), .ins_ready(ins_ready),
    .ins_bucket(ins_bucket), .ins_ptr(ins_ptr), .rsp_valid(rsp_valid),
    .rsp_status(rsp_status), .rsp_node(rsp_node), .rsp_evict_ptr(rsp_evict_ptr),
    .inv_ptr(inv_ptr), .dinv_req(dinv_req), .dinv_rdy(dinv_rdy), .dinv_ack(dinv_ack),
    .tinv_req(tinv_req), .tinv_rdy(tinv_rdy), .tinv_ack(tinv_ack),
    .shr_valid(shr_valid), .shr_bucket(shr_bucket), .shr_node(shr_node),
    .shr_flag(shr_flag)
  );

  int n_chk = 0;
  int n_err = 0;
  bit finished = 0;

  bit          mv [NB][NN];
  bit          ms [NB][NN];
  logic [PW-1:0] mp [NB][NN];

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // expected outcome from the model: 0 free, 1 replace, 2 skip
  function automatic int exp_outcome(input int b, output int node);
    node = 0;
    for (int i = 0; i < NN; i++) if (!mv[b][i]) begin node = i; return 0; end
    for (int i = 0; i < NN; i++) if (!ms[b][i]) begin node = i; return 1; end
    return 2;
  endfunction

  task automatic do_shr(input int b, input int n, input bit f);
    @(negedge clk);
    shr_valid = 1'b1; shr_bucket = BW'(b); shr_node = NW'(n); shr_flag = f;
    @(negedge clk);
    shr_valid = 1'b0;
    ms[b][n] = f;
  endtask

  task automatic do_ins(input int b, input logic [PW-1:0] p);
    int eo, en, dhs, ths, dw, tw;
    bit dacked, got;
    logic [PW-1:0] old;
    eo = exp_outcome(b, en);
    old = mp[b][en];
    dhs = 0; ths = 0; dw = 0; tw = 0; dacked = 0; got = 0;
    @(negedge clk);
    check(ins_ready == 1'b1, "R8 idle ready", int'(ins_ready), 1);
    ins_valid = 1'b1; ins_bucket = BW'(b); ins_ptr = p;
    @(negedge clk);
    ins_valid = 1'b0;
    check(ins_ready == 1'b0, "R8 busy", int'(ins_ready), 0);
    for (int c = 0; c < 200 && !got; c++) begin
      if (rsp_valid) begin
        got = 1;
        dinv_ack = 0; tinv_ack = 0; dinv_rdy = 0; tinv_rdy = 0;
      end else begin
        dinv_ack = 0; tinv_ack = 0;
        if (dw == 1) begin dinv_ack = 1; dacked = 1; end
        if (dw > 0) dw--;
        if (tw == 1) tinv_ack = 1;
        if (tw > 0) tw--;
        if (tinv_req && !dacked) check(0, "R5 tag before data ack", 1, 0);
        dinv_rdy = 1'($urandom % 2);
        tinv_rdy = 1'($urandom % 2);
        if (dinv_req && dinv_rdy) begin
          dhs++; dw = 1 + int'($urandom % 3);
          check(inv_ptr == old, "R5 data inv ptr", int'(inv_ptr), int'(old));
        end
        if (tinv_req && tinv_rdy) begin
          ths++; tw = 1 + int'($urandom % 3);
          check(inv_ptr == old, "R5 tag inv ptr", int'(inv_ptr), int'(old));
        end
        @(negedge clk);
      end
    end
    check(got, "R10 response seen", int'(got), 1);
    check(int'(rsp_status) == eo, eo == 0 ? "R2 status" : (eo == 1 ? "R4 status" : "R7 status"),
          int'(rsp_status), eo);
    if (eo != 2) check(int'(rsp_node) == en, eo == 0 ? "R2 node" : "R4 victim node",
                       int'(rsp_node), en);
    if (eo == 1) begin
      check(rsp_evict_ptr == old, "R4 evict ptr", int'(rsp_evict_ptr), int'(old));
      check(dhs == 1 && ths == 1, "R5 one handshake each", dhs * 10 + ths, 11);
    end else begin
      check(rsp_evict_ptr == '0, "R10 evict zero", int'(rsp_evict_ptr), 0);
      check(dhs == 0 && ths == 0, eo == 0 ? "R3 no inv" : "R7 no inv", dhs * 10 + ths, 0);
    end
    @(negedge clk);
    check(rsp_valid == 1'b0, "R10 pulse", int'(rsp_valid), 0);
    if (eo != 2) begin
      mv[en][0] = mv[en][0];
      mv[b][en] = 1; ms[b][en] = 0; mp[b][en] = p;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_err++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    for (int b = 0; b < NB; b++)
      for (int n = 0; n < NN; n++) begin mv[b][n] = 0; ms[b][n] = 0; mp[b][n] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(ins_ready == 1'b1, "R1 ready", int'(ins_ready), 1);
    check(rsp_valid == 1'b0, "R1 rsp", int'(rsp_valid), 0);
    check(dinv_req == 1'b0 && tinv_req == 1'b0, "R1 inv", int'(dinv_req) + int'(tinv_req), 0);

    // directed: fill bucket 1 (R2), all shared skip (R7), R9 unshare one, replace (R4 R6)
    for (int i = 0; i < NN; i++) do_ins(1, PW'(8'h10 + i));
    for (int i = 0; i < NN; i++) do_shr(1, i, 1'b1);
    do_ins(1, 8'hA0);
    do_ins(1, 8'hA1);
    do_shr(1, 2, 1'b0); // R9
    do_ins(1, 8'hB2);   // victim node 2
    do_ins(1, 8'hB3);   // R6: node 2 now holds B2 unshared, replaced again
    do_shr(1, 0, 1'b0);
    do_ins(1, 8'hC0);   // lowest unshared is node 0

    // random mix
    for (int k = 0; k < 400; k++) begin
      if ($urandom % 10 < 6) do_ins(int'($urandom % NB), PW'($urandom));
      else do_shr(int'($urandom % NB), int'($urandom % NN), ($urandom % 4) != 0);
    end

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

endmodule